// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block carries 32-bit words from one clock domain to another, independent one. The writer presents a word with a write strobe on its own clock. The reader sees the oldest stored word on its data output without asking for it, on its own clock. A read strobe consumes that word and brings the next one forward. The read-side empty flag is therefore also the valid flag for the output data.

Storage is an inferred memory array. Its depth is the number of memory blocks times the words per block. A one-word output register sits in front of the array.

The write and read pointers cross between the domains as Gray codes through two-stage synchronizers. Full is decided in the write domain and empty in the read domain. A protocol violation on either side raises that side's error flag for one cycle:

- a write attempt while full;
- a read attempt while empty.

A 2-bit fill indication, in quarters of the array depth, is produced in the write domain for status display.

Top module: `xclk_fwft_fifo`

## Requirements
- R1: While `rst_n` is low, and after its release until the first write, `rd_empty` is 1, `wr_full` is 0, `wr_err` and `rd_err` are 0, and `wr_level` is 0.
- R2: Every accepted word leaves on `rd_data` exactly once, in the order written. This holds for any ratio and phase of the two clocks.
- R3: While `rd_empty` is 0, `rd_data` holds the oldest unread word. Without `rd_en` it stays unchanged and `rd_empty` stays 0.
- R4: A write is accepted only at a `wr_clk` edge with `wr_en`=1 and `wr_full`=0. While `wr_full` is 1, `wr_en` stores nothing. With the reader idle and the output word already loaded, `wr_full` rises once DEPTH+1 words are held (DEPTH = BLOCK_N*BLOCK_WORDS, a power of two).
- R5: `wr_err` is 1 for exactly the one `wr_clk` cycle after each edge where `wr_en`=1 and `wr_full`=1, and 0 otherwise.
- R6: `rd_err` is 1 for exactly the one `rd_clk` cycle after each edge where `rd_en`=1 and `rd_empty`=1, and 0 otherwise. Such a read changes neither `rd_empty` nor the stored data.
- R7: After a word is written into an empty FIFO, `rd_empty` falls within 8 `rd_clk` cycles, and `rd_data` then shows that word.
- R8: `wr_level` is a registered value equal to min(3, floor(4*N/DEPTH)). N is the word count of the array as seen by the write domain, excluding the output register. `wr_level` is 3 whenever `wr_full` is 1.
- R9: The read pointer, as it crosses to the write domain, changes by at most one bit per `rd_clk` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store; held stable while full |
| wr_full | output | 1 | No room for a write |
| wr_err | output | 1 | One-cycle flag: write attempted while full |
| wr_level | output | 2 | Array fill in quarters of DEPTH |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Consume the word on `rd_data` |
| rd_data | output | DATA_W | Oldest word (valid when `rd_empty` is 0) |
| rd_empty | output | 1 | No valid word on `rd_data` |
| rd_err | output | 1 | One-cycle flag: read attempted while empty |

## Verification
The bench builds the block with BLOCK_N=2 and BLOCK_WORDS=4, giving an eight-word array. With so few words, the full boundary and the DEPTH+1 capacity are reached after a handful of writes. The same small depth puts each quarter step of the fill indication only two words apart. Pointer wrap-around then happens many times during the random traffic. That traffic runs a 5 ns write clock against a 7 ns read clock, so the pointer synchronizers see every phase relation.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  typedef logic [1:0] fill_t;
  localparam fill_t FILL_TOP    = 2'd3;
  localparam int    SYNC_STAGES = 2;
endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import xfifo_pkg::*;

  logic [W-1:0] stg_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/xfifo_wr_ctrl.sv
module xfifo_wr_ctrl #(
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW:0]      rgray_s,
  output logic             wr_full,
  output logic             wr_err,
  output xfifo_pkg::fill_t wr_level,
  output logic             commit,
  output logic [AW-1:0]    waddr,
  output logic [AW:0]      wgray
);
  import xfifo_pkg::*;

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wbin_nx, wgray_q, wgray_nx, rbin_s, cnt_nx;
  logic          full_q, full_nx, err_q, err_nx;
  fill_t         lvl_q, lvl_nx;

  always_comb begin
    commit   = wr_en & ~full_q;
    wbin_nx  = wbin_q + PW'(commit);
    wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    rbin_s[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    cnt_nx   = wbin_nx - rbin_s;
    full_nx  = (wgray_nx == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    lvl_nx   = (cnt_nx >= PW'(DEPTH)) ? FILL_TOP : fill_t'(cnt_nx >> (AW - 2));
    err_nx   = wr_en & full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
      lvl_q   <= '0;
    end else begin
      if (commit) begin
        wbin_q  <= wbin_nx;
        wgray_q <= wgray_nx;
      end
      full_q <= full_nx;
      err_q  <= err_nx;
      lvl_q  <= lvl_nx;
    end
  end

  assign wr_full  = full_q;
  assign wr_err   = err_q;
  assign wr_level = lvl_q;
  assign waddr    = wbin_q[AW-1:0];
  assign wgray    = wgray_q;
endmodule

// File: rtl/xfifo_rd_ctrl.sv
module xfifo_rd_ctrl #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_err
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_q, rbin_nx, rgray_q, rgray_nx;
  logic [DW-1:0] data_q;
  logic          valid_q, valid_nx, err_q, err_nx;
  logic          has_word, take, load;

  always_comb begin
    has_word = (rgray_q != wgray_s);
    take     = rd_en & valid_q;
    load     = has_word & (~valid_q | rd_en);
    valid_nx = load | (valid_q & ~take);
    rbin_nx  = rbin_q + PW'(1);
    rgray_nx = rbin_nx ^ (rbin_nx >> 1);
    err_nx   = rd_en & ~valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (load) begin
        rbin_q  <= rbin_nx;
        rgray_q <= rgray_nx;
        data_q  <= mem_q;
      end
      valid_q <= valid_nx;
      err_q   <= err_nx;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign rgray    = rgray_q;
  assign rd_data  = data_q;
  assign rd_empty = ~valid_q;
  assign rd_err   = err_q;
endmodule

// File: rtl/xclk_fwft_fifo.sv
module xclk_fwft_fifo #(
  parameter int DATA_W      = 32,
  parameter int BLOCK_N     = 1,
  parameter int BLOCK_WORDS = 512
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic              wr_err,
  output logic [1:0]        wr_level,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_err
);
  localparam int DEPTH = BLOCK_N * BLOCK_WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic              wr_srst_n, rd_srst_n, wr_commit;
  logic [AW-1:0]     waddr, raddr;
  logic [AW:0]       wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] mem [DEPTH];

  xfifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
  xfifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

  xfifo_sync #(.W(AW + 1)) u_r2w (
    .clk(wr_clk), .rst_n(wr_srst_n), .d(rgray), .q(rgray_s));
  xfifo_sync #(.W(AW + 1)) u_w2r (
    .clk(rd_clk), .rst_n(rd_srst_n), .d(wgray), .q(wgray_s));

  xfifo_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_srst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .wr_full(wr_full), .wr_err(wr_err), .wr_level(wr_level),
    .commit(wr_commit), .waddr(waddr), .wgray(wgray));

  always_ff @(posedge wr_clk) begin
    if (wr_commit) mem[waddr] <= wr_data;
  end

  assign mem_q = mem[raddr];

  xfifo_rd_ctrl #(.AW(AW), .DW(DATA_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_srst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .mem_q(mem_q), .raddr(raddr), .rgray(rgray), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_err(rd_err));
endmodule

// File: rtl/xclk_fwft_fifo_chk.sv
module xclk_fwft_fifo_chk #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input logic          rst_n,
  input logic          wr_clk,
  input logic          wr_en,
  input logic          wr_full,
  input logic          wr_err,
  input logic [1:0]    wr_level,
  input logic [AW:0]   wgray,
  input logic          rd_clk,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          rd_empty,
  input logic          rd_err,
  input logic [AW:0]   rgray
);
  AST_WERR_CAUSE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en && wr_full)); // R5
  AST_RERR_CAUSE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_err |-> $past(rd_en && rd_empty)); // R6
  AST_HEAD_HOLDS: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!rd_empty && !rd_en) |=> (!rd_empty && $stable(rd_data))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_full && wr_en) |=> $stable(wgray)); // R4
  AST_FULL_LEVEL: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_full |-> (wr_level == 2'd3)); // R8
  AST_RPTR_GRAY: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R9
endmodule

bind xclk_fwft_fifo xclk_fwft_fifo_chk #(.AW(AW), .DW(DATA_W)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_full(wr_full),
  .wr_err(wr_err), .wr_level(wr_level), .wgray(wgray), .rd_clk(rd_clk),
  .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .rd_err(rd_err),
  .rgray(rgray));

// File: tb/xclk_fwft_fifo_test.sv
module xclk_fwft_fifo_test;
  localparam int DW = 32;
  localparam int BN = 2;
  localparam int BW = 4;
  localparam int DEPTH = BN * BW;
  localparam int NRAND = 1500;

  logic          rst_n, wr_clk, rd_clk, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic          wr_full, wr_err, rd_empty, rd_err;
  logic [1:0]    wr_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DW-1:0] q[$];

  xclk_fwft_fifo #(.DATA_W(DW), .BLOCK_N(BN), .BLOCK_WORDS(BW)) uut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_err(wr_err), .wr_level(wr_level),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_err(rd_err));

  initial wr_clk = 1'b0;
  always #2.5 wr_clk = ~wr_clk;
  initial rd_clk = 1'b0;
  always #3.5 rd_clk = ~rd_clk;

  function automatic logic [1:0] exp_level(int n);
    int v = (4 * n) / DEPTH;
    return (v > 3) ? 2'd3 : 2'(v);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = d;
    if (!wr_full) q.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      rd_en = 1'b0;
      for (int k = 0; k < 20 && rd_empty; k++) @(negedge rd_clk);
      chk(!rd_empty && q.size() > 0 && rd_data == q[0], "R2", "drain order",
          rd_data, (q.size() > 0) ? q[0] : '0);
      if (q.size() > 0) void'(q.pop_front());
      rd_en = 1'b1;
    end
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int acc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    #40;
    // R1 during reset
    chk(rd_empty && !wr_full && !wr_err && !rd_err && wr_level == 0, "R1",
        "flags in reset", {rd_empty, wr_full, wr_err, rd_err, wr_level}, 32'h20);
    @(negedge wr_clk); rst_n = 1'b1;
    repeat (10) @(negedge wr_clk);
    chk(rd_empty && !wr_full && !wr_err && !rd_err && wr_level == 0, "R1",
        "flags after release", {rd_empty, wr_full, wr_err, rd_err, wr_level}, 32'h20);

    // R7 / R3: single word falls through
    put(32'hA5A5_0001);
    repeat (8) @(negedge rd_clk);
    chk(!rd_empty, "R7", "empty falls after write", rd_empty, 0);
    chk(rd_data == 32'hA5A5_0001, "R3", "head word shown", rd_data, 32'hA5A5_0001);
    repeat (5) @(negedge rd_clk);
    chk(!rd_empty && rd_data == 32'hA5A5_0001, "R3", "head holds without read",
        rd_data, 32'hA5A5_0001);
    chk(wr_level == exp_level(0), "R8", "level with array empty", wr_level, exp_level(0));

    // R8: four words in the array
    for (int i = 0; i < 4; i++) put(32'hB000_0000 + i);
    repeat (4) @(negedge wr_clk);
    chk(wr_level == exp_level(4), "R8", "level at half", wr_level, exp_level(4));

    // R4: fill to full; total held must be DEPTH+1
    acc = 5;
    @(negedge wr_clk);
    while (!wr_full && acc < DEPTH + 4) begin
      wr_en = 1'b1; wr_data = 32'hC000_0000 + acc;
      q.push_back(wr_data); acc++;
      @(negedge wr_clk);
    end
    wr_en = 1'b0;
    chk(acc == DEPTH + 1, "R4", "words held at full", acc, DEPTH + 1);
    chk(wr_full == 1'b1, "R4", "full flag", wr_full, 1);
    chk(wr_level == 2'd3, "R8", "level at full", wr_level, 3);

    // R5: write while full
    wr_en = 1'b1; wr_data = 32'hDEAD_BEEF;
    @(negedge wr_clk);
    wr_en = 1'b0;
    chk(wr_err == 1'b1, "R5", "error after full write", wr_err, 1);
    @(negedge wr_clk);
    chk(wr_err == 1'b0, "R5", "error lasts one cycle", wr_err, 0);
    chk(wr_full == 1'b1, "R4", "still full after rejected write", wr_full, 1);

    // R2/R4: drain; rejected word must not appear
    drain(DEPTH + 1);
    repeat (6) @(negedge rd_clk);
    chk(rd_empty == 1'b1, "R4", "empty after DEPTH+1 reads, no extra word", rd_empty, 1);
    repeat (8) @(negedge wr_clk);
    chk(wr_full == 1'b0 && wr_level == 0, "R4", "full clears after drain",
        {wr_full, wr_level}, 0);

    // R6: read while empty
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(rd_err == 1'b1 && rd_empty, "R6", "error after empty read", {rd_err, rd_empty}, 3);
    @(negedge rd_clk);
    chk(rd_err == 1'b0 && rd_empty, "R6", "error lasts one cycle", {rd_err, rd_empty}, 1);
    put(32'h0600_0006);
    repeat (8) @(negedge rd_clk);
    chk(rd_data == 32'h0600_0006, "R6", "data unaffected by empty read", rd_data, 32'h0600_0006);
    drain(1);

    // R2: random traffic across both clocks
    fork
      begin
        for (int i = 0; i < NRAND; i++) begin
          logic [DW-1:0] d = $urandom;
          repeat ($urandom_range(0, 2)) @(negedge wr_clk);
          @(negedge wr_clk);
          wr_en = 1'b1; wr_data = d;
          while (wr_full) @(negedge wr_clk);
          q.push_back(d);
          @(negedge wr_clk);
          wr_en = 1'b0;
          if (!wr_full) begin end
        end
      end
      begin
        int got = 0;
        while (got < NRAND) begin
          @(negedge rd_clk);
          rd_en = ($urandom_range(0, 3) != 0);
          if (rd_en && !rd_empty) begin
            chk(q.size() > 0 && rd_data == q[0], "R2", "random order",
                rd_data, (q.size() > 0) ? q[0] : '0);
            if (q.size() > 0) void'(q.pop_front());
            got++;
          end
        end
        @(negedge rd_clk);
        rd_en = 1'b0;
      end
    join
    repeat (10) @(negedge rd_clk);
    chk(rd_empty && q.size() == 0, "R2", "all words delivered", q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule